// File: doc/BRIEF.md
# I/O Permission Bitmap Checker

This block decides whether an I/O port access by a task may proceed or must raise a general-protection fault. A request gives the base address of the task-state segment, its limit, the 16-bit port number and the access width in bytes (1, 2 or 4). The block then reads the 16-bit offset of the permission bitmap from the task-state segment through a byte-wide memory read port. It fetches the one or two bitmap bytes whose bits cover the accessed ports and returns a one-cycle verdict.

Each port has one bit in the bitmap. A set bit denies the access. A clear bit allows it. The bitmap can be up to 8 KB long, which is one bit for each of the 65536 ports. Any bitmap byte lying past the segment limit counts as denied, so a short segment denies the ports at the top of the range. The block checks the limit before it issues any bitmap read. It never touches memory outside the segment.

Top module: `iopb_access_check`

## Requirements
- R1: While reset is asserted, and until the synchronised reset has been released, `req_ready` is low and `rd_en`, `done`, `allow` and `fault` are low. After that the block is idle with `req_ready` high.
- R2: A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` stays low from that edge until the cycle that shows `done`, and no read strobe is raised while `req_ready` is high.
- R3: If the segment limit is below 0x67, the request completes one cycle after acceptance with `fault`, and no memory read is issued.
- R4: Otherwise the first read goes to segment base + 0x66, which is the low byte of the bitmap offset. The second read goes to base + 0x67, which is the high byte.
- R5: `rd_en` and `rd_addr` stay unchanged until a cycle in which `rd_ready` is high. `rd_data` is taken in that cycle.
- R6: The bit for port P is bit (P mod 8) of the byte at base + offset + floor(P/8). A value of 1 denies the access and 0 allows it.
- R7: An access of N bytes at port P is allowed only when the bits for ports P to P+N-1 are all 0. When those bits run past bit 7, the next byte (address + 1) is read as well.
- R8: Offsets are measured from the segment base, and a byte at an offset equal to the limit is still inside. If any bitmap byte the access needs lies past the limit, the result is `fault` and no bitmap byte is read.
- R9: If the first bitmap byte already denies the access, the second byte is not read.
- R10: `done` is a one-cycle strobe, and in that cycle exactly one of `allow` and `fault` is high. Both are low whenever `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Block idle and able to take a request |
| req_base | input | AW | Segment base address |
| req_limit | input | AW | Segment limit (last valid byte offset) |
| req_port | input | 16 | First port of the access |
| req_size | input | 3 | Access width in bytes: 1, 2 or 4 |
| rd_en | output | 1 | Memory byte read request |
| rd_addr | output | AW | Memory byte address |
| rd_ready | input | 1 | Read handshake; `rd_data` valid in the same cycle |
| rd_data | input | 8 | Memory read data |
| done | output | 1 | Verdict strobe |
| allow | output | 1 | Access permitted (with `done`) |
| fault | output | 1 | Access denied, general-protection fault (with `done`) |

## Verification
The assertions check the following on every cycle: read requests hold steady while they wait, the two offset reads follow acceptance in order, and a short segment faults with no memory traffic. They also check that each address issued stays within the accepted limit, and that the verdict outputs are mutually exclusive and qualified by `done`. Some behaviour only the bench scenarios can show. This covers the mapping of each port to a bit and the deny decision across two bytes. It also covers the early exit when the first byte already denies, and the exact boundary where a byte sits at or just past the limit. The bench compares each of these against its own model over directed and random cases, with random wait states on the read port.

// File: rtl/iopb_pkg.sv
package iopb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_OFF_LO = 3'd1,
    ST_OFF_HI = 3'd2,
    ST_EVAL   = 3'd3,
    ST_MAP0   = 3'd4,
    ST_MAP1   = 3'd5
  } iopb_state_e;

  // byte offset of the bitmap-offset field inside the segment
  localparam int unsigned MAP_OFS_LO  = 32'h66;
  localparam int unsigned MAP_OFS_HI  = 32'h67;
  // smallest limit that still holds the bitmap-offset field
  localparam int unsigned MIN_LIMIT   = 32'h67;
endpackage

// File: rtl/iopb_rst_sync.sv
module iopb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/iopb_mask_gen.sv
// Builds the bit mask that an access of req_size bytes covers, starting at
// bit position bit_pos of the first bitmap byte, spread over two bytes.
module iopb_mask_gen #(
  parameter int SIZE_W = 3
) (
  input  logic [2:0]        bit_pos,
  input  logic [SIZE_W-1:0] size,
  output logic [7:0]        mask_lo,
  output logic [7:0]        mask_hi,
  output logic              spans
);
  localparam int RUN_W = 16;

  logic [RUN_W-1:0] run;
  logic [RUN_W-1:0] shifted;

  always_comb begin
    run     = RUN_W'((32'd1 << size) - 32'd1);
    shifted = run << bit_pos;
    mask_lo = shifted[7:0];
    mask_hi = shifted[15:8];
    spans   = |shifted[15:8];
  end
endmodule

// File: rtl/iopb_addr_calc.sv
// Bitmap byte offsets, their memory addresses and the limit test.
module iopb_addr_calc #(
  parameter int AW     = 32,
  parameter int PORT_W = 16
) (
  input  logic [AW-1:0]       base,
  input  logic [AW-1:0]       limit,
  input  logic [15:0]         map_ofs,
  input  logic [PORT_W-4:0]   byte_idx,
  input  logic                spans,
  output logic [AW-1:0]       addr0,
  output logic [AW-1:0]       addr1,
  output logic                in_limit
);
  localparam int OW = AW + 1;

  logic [OW-1:0] ofs0;
  logic [OW-1:0] ofs1;
  logic [OW-1:0] ofs_last;

  always_comb begin
    ofs0     = OW'(map_ofs) + OW'(byte_idx);
    ofs1     = ofs0 + OW'(1);
    ofs_last = spans ? ofs1 : ofs0;
    in_limit = (ofs_last <= OW'(limit));
    addr0    = base + ofs0[AW-1:0];
    addr1    = base + ofs1[AW-1:0];
  end
endmodule

// File: rtl/iopb_access_check.sv
module iopb_access_check
  import iopb_pkg::*;
#(
  parameter int AW     = 32,
  parameter int PORT_W = 16,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_base,
  input  logic [AW-1:0]     req_limit,
  input  logic [PORT_W-1:0] req_port,
  input  logic [SIZE_W-1:0] req_size,
  output logic              rd_en,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ready,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              allow,
  output logic              fault
);
  logic rst_n_int;

  iopb_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  iopb_state_e        state_q, state_d;
  logic               done_q, done_d;
  logic               allow_q, allow_d;
  logic [AW-1:0]      base_q;
  logic [AW-1:0]      limit_q;
  logic [PORT_W-1:0]  port_q;
  logic [SIZE_W-1:0]  size_q;
  logic [15:0]        map_ofs_q;

  logic               accept_en;
  logic               lo_en;
  logic               hi_en;

  logic [7:0]         mask_lo;
  logic [7:0]         mask_hi;
  logic               spans;
  logic [AW-1:0]      map_addr0;
  logic [AW-1:0]      map_addr1;
  logic               map_in_limit;

  iopb_mask_gen #(.SIZE_W(SIZE_W)) u_mask (
    .bit_pos (port_q[2:0]),
    .size    (size_q),
    .mask_lo (mask_lo),
    .mask_hi (mask_hi),
    .spans   (spans)
  );

  iopb_addr_calc #(.AW(AW), .PORT_W(PORT_W)) u_addr (
    .base     (base_q),
    .limit    (limit_q),
    .map_ofs  (map_ofs_q),
    .byte_idx (port_q[PORT_W-1:3]),
    .spans    (spans),
    .addr0    (map_addr0),
    .addr1    (map_addr1),
    .in_limit (map_in_limit)
  );

  assign req_ready = rst_n_int && (state_q == ST_IDLE);
  assign accept_en = req_ready && req_valid;
  assign lo_en     = (state_q == ST_OFF_LO) && rd_ready;
  assign hi_en     = (state_q == ST_OFF_HI) && rd_ready;

  // next-state and verdict
  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    allow_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept_en) begin
          if (req_limit < AW'(MIN_LIMIT)) begin
            done_d = 1'b1;
          end else begin
            state_d = ST_OFF_LO;
          end
        end
      end
      ST_OFF_LO: begin
        if (rd_ready) state_d = ST_OFF_HI;
      end
      ST_OFF_HI: begin
        if (rd_ready) state_d = ST_EVAL;
      end
      ST_EVAL: begin
        if (!map_in_limit) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_MAP0;
        end
      end
      ST_MAP0: begin
        if (rd_ready) begin
          if (|(rd_data & mask_lo)) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (spans) begin
            state_d = ST_MAP1;
          end else begin
            done_d  = 1'b1;
            allow_d = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_MAP1: begin
        if (rd_ready) begin
          done_d  = 1'b1;
          allow_d = ~|(rd_data & mask_hi);
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      allow_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      allow_q <= allow_d;
    end
  end

  // request datapath registers, loaded on acceptance
  always_ff @(posedge clk) begin
    if (accept_en) begin
      base_q  <= req_base;
      limit_q <= req_limit;
      port_q  <= req_port;
      size_q  <= req_size;
    end
  end

  // bitmap offset registers, loaded by the two offset reads
  always_ff @(posedge clk) begin
    if (lo_en) map_ofs_q[7:0]  <= rd_data;
    if (hi_en) map_ofs_q[15:8] <= rd_data;
  end

  // memory read port
  always_comb begin
    rd_en   = 1'b0;
    rd_addr = '0;
    case (state_q)
      ST_OFF_LO: begin rd_en = 1'b1; rd_addr = base_q + AW'(MAP_OFS_LO); end
      ST_OFF_HI: begin rd_en = 1'b1; rd_addr = base_q + AW'(MAP_OFS_HI); end
      ST_MAP0:   begin rd_en = 1'b1; rd_addr = map_addr0; end
      ST_MAP1:   begin rd_en = 1'b1; rd_addr = map_addr1; end
      default:   begin rd_en = 1'b0; rd_addr = '0; end
    endcase
  end

  assign done  = done_q;
  assign allow = done_q & allow_q;
  assign fault = done_q & ~allow_q;
endmodule

// File: rtl/iopb_access_check_sva.sv
module iopb_access_check_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_base,
  input logic [AW-1:0] req_limit,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ready,
  input logic          done,
  input logic          allow,
  input logic          fault
);
  logic [AW-1:0] acc_base_q;
  logic [AW-1:0] acc_limit_q;
  logic          accepted;

  assign accepted = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_base_q  <= '0;
      acc_limit_q <= '0;
    end else if (accepted) begin
      acc_base_q  <= req_base;
      acc_limit_q <= req_limit;
    end
  end

  p_no_read_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rd_en);

  p_short_segment_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && (req_limit < AW'(32'h67))) |=> (done && fault && !rd_en));

  p_first_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted && (req_limit >= AW'(32'h67))) |=> (rd_en && (rd_addr == $past(req_base) + AW'(32'h66))));

  p_second_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_ready && (rd_addr == acc_base_q + AW'(32'h66))) |=> (rd_en && (rd_addr == acc_base_q + AW'(32'h67))));

  p_read_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_ready) |=> (rd_en && $stable(rd_addr)));

  p_read_in_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ((rd_addr - acc_base_q) <= acc_limit_q));

  p_verdict_one_hot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({allow, fault}));

  p_verdict_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!allow && !fault));
endmodule

bind iopb_access_check iopb_access_check_sva #(.AW(AW)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_base  (req_base),
  .req_limit (req_limit),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .rd_ready  (rd_ready),
  .done      (done),
  .allow     (allow),
  .fault     (fault)
);

// File: tb/iopb_access_check_bench.sv
module iopb_access_check_bench;
  localparam int          AW      = 32;
  localparam logic [31:0] TB_BASE = 32'h0001_0000;
  localparam int          WIN     = 4096;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_base;
  logic [AW-1:0] req_limit;
  logic [15:0]   req_port;
  logic [2:0]    req_size;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic          rd_ready;
  logic [7:0]    rd_data;
  logic          done;
  logic          allow;
  logic          fault;

  int vectors;
  int miscompares;
  bit all_done;
  bit [7:0] tmem [WIN];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  iopb_access_check #(.AW(AW)) u_iopb_access_check (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_limit(req_limit), .req_port(req_port),
    .req_size(req_size), .rd_en(rd_en), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_data(rd_data), .done(done), .allow(allow), .fault(fault)
  );

  function automatic bit [7:0] mem_at(logic [31:0] a);
    logic [31:0] i;
    i = a - TB_BASE;
    return (i < WIN) ? tmem[i[11:0]] : 8'hFF;
  endfunction

  always_comb rd_data = mem_at(rd_addr);

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic set_map_ofs(int ofs);
    tmem[16'h66] = ofs[7:0];
    tmem[16'h67] = ofs[15:8];
  endtask

  task automatic fill_bitmap();
    for (int i = 0; i < WIN; i++)
      tmem[i] = (($urandom % 3) == 0) ? (8'h01 << ($urandom % 8)) : 8'h00;
  endtask

  // one request, compared against a behavioural model on every clock
  task automatic run_req(logic [31:0] lim, logic [15:0] port, logic [2:0] sz, string req);
    logic [31:0] q[$];
    bit          exp_allow;
    int          ofs;
    int          first;
    int          need2;
    int          m;
    int          cyc;
    bit          finished;
    exp_allow = 1'b0;
    if (lim >= 32'h67) begin
      q.push_back(TB_BASE + 32'h66);
      q.push_back(TB_BASE + 32'h67);
      ofs   = int'(tmem[16'h66]) + (int'(tmem[16'h67]) << 8);
      first = ofs + int'(port) / 8;
      m     = ((1 << sz) - 1) << (port % 8);
      need2 = ((m >> 8) != 0) ? 1 : 0;
      if (first + need2 <= int'(lim)) begin
        q.push_back(TB_BASE + first);
        if ((int'(mem_at(TB_BASE + first)) & (m & 8'hFF)) == 0) begin
          if (need2 != 0) begin
            q.push_back(TB_BASE + first + 1);
            exp_allow = ((int'(mem_at(TB_BASE + first + 1)) & (m >> 8)) == 0);
          end else begin
            exp_allow = 1'b1;
          end
        end
      end
    end
    @(negedge clk);
    check(req_ready == 1'b1, "R2", "ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_base = TB_BASE; req_limit = lim;
    req_port = port; req_size = sz; rd_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    finished = 1'b0;
    while (!finished) begin
      rd_ready = (($urandom % 3) != 0);
      #1;
      if (done) begin
        check(allow == exp_allow, req, "allow", 32'(allow), 32'(exp_allow));
        check(fault == !exp_allow, "R10", "fault", 32'(fault), 32'(!exp_allow));
        check(q.size() == 0, req, "reads still expected", 32'(q.size()), 32'd0);
        finished = 1'b1;
      end else begin
        check(!allow && !fault, "R10", "verdict without done", {allow, fault}, 32'd0);
        check(req_ready == 1'b0, "R2", "ready while busy", 32'(req_ready), 32'd0);
        if (rd_en && rd_ready) begin
          if (q.size() == 0) begin
            check(1'b0, req, "unexpected read", rd_addr, 32'hFFFF_FFFF);
          end else begin
            check(rd_addr == q[0], req, "read address", rd_addr, q[0]);
            void'(q.pop_front());
          end
        end
        @(negedge clk);
        cyc++;
        if (cyc > 300) begin
          check(1'b0, req, "request never finished", 32'(cyc), 32'd0);
          finished = 1'b1;
        end
      end
    end
    rd_ready = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R10", "done longer than one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    vectors = 0; miscompares = 0; all_done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_base = '0; req_limit = '0;
    req_port = '0; req_size = 3'd1; rd_ready = 1'b0;
    for (int i = 0; i < WIN; i++) tmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(!rd_en && !done && !allow && !fault && !req_ready, "R1", "outputs in reset",
          {rd_en, done, allow, fault, req_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1 && !rd_en && !done, "R1", "idle after reset",
          {req_ready, rd_en, done}, 32'b100);

    set_map_ofs(32'h80);
    run_req(32'h60, 16'd5, 3'd1, "R3");
    run_req(32'h66, 16'd5, 3'd1, "R3");
    run_req(32'hFFF, 16'd16, 3'd1, "R4");
    tmem[16'h82] = 8'h01;
    run_req(32'hFFF, 16'd16, 3'd1, "R6");
    run_req(32'hFFF, 16'd17, 3'd1, "R6");
    tmem[16'h83] = 8'h02;
    run_req(32'hFFF, 16'd22, 3'd4, "R7");
    tmem[16'h83] = 8'h00;
    run_req(32'hFFF, 16'd22, 3'd4, "R7");
    run_req(32'hFFF, 16'd31, 3'd2, "R7");
    tmem[16'h83] = 8'h80;
    run_req(32'hFFF, 16'd30, 3'd2, "R7");
    tmem[16'h82] = 8'h80;
    run_req(32'hFFF, 16'd23, 3'd4, "R9");
    tmem[16'h82] = 8'h00; tmem[16'h83] = 8'h00;
    tmem[16'h85] = 8'h00; tmem[16'h86] = 8'h00;
    run_req(32'h85, 16'd40, 3'd1, "R8");
    run_req(32'h85, 16'd48, 3'd1, "R8");
    run_req(32'h85, 16'd47, 3'd2, "R8");
    set_map_ofs(32'hF000);
    run_req(32'hFFF, 16'd0, 3'd1, "R8");

    for (int n = 0; n < 400; n++) begin
      int ofs;
      int port;
      int k;
      logic [31:0] lim;
      logic [2:0]  sz;
      if ((n % 50) == 0) fill_bitmap();
      ofs  = 32'h68 + ($urandom % 32'h200);
      set_map_ofs(ofs);
      port = $urandom % ((WIN - 1 - ofs) * 8);
      k    = $urandom % 4;
      if (k == 0)      lim = 32'h40 + ($urandom % 32'h27);
      else if (k == 1) lim = 32'hFFF;
      else             lim = 32'(ofs + port / 8 + int'($urandom % 3) - 1);
      case ($urandom % 3)
        0:       sz = 3'd1;
        1:       sz = 3'd2;
        default: sz = 3'd4;
      endcase
      run_req(lim, 16'(port), sz, "R7");
    end

    all_done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!all_done) begin
      miscompares++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule